// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Extension

This block is the integer execute stage of a 32-bit load/store pipeline. Each cycle it may accept one instruction word together with the two register values the caller read from the register file. It decodes the 6-bit major opcode and decides whether the instruction is a register-register or a register-immediate operation. It extends the 16-bit immediate by the rule that belongs to that operation, evaluates the operation, and registers a 32-bit result, a destination register index and a write enable. Source register indices are decoded combinationally and driven out, so the register file can supply operand values in the same cycle.

The supported operations are:
- add, subtract and multiply (low word of the product);
- the bitwise and, or, xor, nor and xnor;
- the and-high and or-high immediate forms;
- six compares that write 0 or 1 into a register;
- logical left shift, arithmetic right shift and logical right shift;
- sign extension of a byte or a halfword.

Every other opcode is accepted and flagged as unsupported, with no register write. Such opcodes include divide, modulus, memory, branch, user-defined and control-register operations.

Top module: `alu_exec`

## Requirements
- R1: Register-register form takes source A index from instr[25:21], source B index from instr[20:16] and the destination from instr[15:11]. `src_a_idx`/`src_b_idx` show instr[25:21]/instr[20:16] in the same cycle. Opcodes add 45, sub 50 (A-B), mul 34 (low 32 bits of A*B), and 40, or 46, xor 38, nor 33 and xnor 41 combine `src_a_val` with `src_b_val`.
- R2: Register-immediate form takes its destination from instr[20:16] and its immediate from instr[15:0]. The immediate is sign-extended for addi 13, muli 2, cmpei 25, cmpgi 26, cmpgei 27 and cmpnei 31.
- R3: The immediate is zero-extended for andi 8, ori 14, xori 6, nori 1, xnori 9, cmpgeui 28 and cmpgui 29.
- R4: andhi 24 and orhi 30 use the immediate in bits 31:16 with zeros in bits 15:0.
- R5: A compare writes 1 when the relation holds and 0 otherwise. The register opcodes are 57 eq, 58 signed gt, 59 signed ge, 60 unsigned ge, 61 unsigned gt and 63 ne. The immediate opcodes 25, 26, 27, 28, 29 and 31 follow the same order.
- R6: Shift left logical uses opcodes 47/15. Shift right arithmetic uses 37/5. Shift right logical uses 32/0. The shift amount is the low 5 bits of `src_b_val` (register form) or of instr[4:0] (immediate form).
- R7: sextb 44 and sexth 55 copy bit 7 or bit 15 of `src_a_val` into all higher bits. The destination comes from instr[15:11].
- R8: One clock edge after `in_valid`=1, `out_valid`=1 and the result and destination appear. After a cycle with `in_valid`=0, `out_valid`, `out_wen` and `out_unsupported` are 0, and `out_result` and `out_dest` hold their values.
- R9: A destination index of 0 forces `out_wen`=0. This includes the no-op, which is addi with all fields zero.
- R10: Any opcode not listed in R1-style decode sets `out_unsupported`=1 with `out_wen`=0 and `out_result`=0, and `out_dest` is taken from instr[15:11]. The listed opcodes are those named in R1 to R7.
- R11: With `rst_n` low at a clock edge, all registered outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_a_val | input | 32 | Value of register selected by `src_a_idx` |
| src_b_val | input | 32 | Value of register selected by `src_b_idx` |
| src_a_idx | output | 5 | Source A register index (combinational) |
| src_b_idx | output | 5 | Source B register index (combinational) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |
| out_dest | output | 5 | Registered destination register index |
| out_wen | output | 1 | Register-file write enable |
| out_unsupported | output | 1 | Opcode outside the supported set |

## Verification
Two functions can fall on the same instruction. Destination-zero suppression can coincide with a compare, with an immediate form whose destination field moves, or with an unsupported opcode. In that cycle the write enable must stay low while the result and the unsupported flag still follow their own rules. Random instruction words produce destination zero in about one word in thirty-two, with opcodes spread over all sixty-four values. Directed words force the no-op and an unsupported opcode aimed at register 0. Each output is compared in the cycle after issue against a model that computes result, destination, write enable and flag from the opcode alone.

// File: rtl/alu_exec_pkg.sv
// Package: shared instruction layout, opcode values and internal enums for
// the integer execute ALU. Assumes a 32-bit instruction with a 6-bit opcode.
package alu_exec_pkg;

    localparam int INSTR_W    = 32;
    localparam int OPC_W      = 6;
    localparam int REG_W      = 5;
    localparam int IMM_W      = 16;
    localparam int OPC_LSB    = INSTR_W - OPC_W;
    localparam int SRCA_LSB   = OPC_LSB - REG_W;
    localparam int SRCB_LSB   = SRCA_LSB - REG_W;
    localparam int DST_RR_LSB = SRCB_LSB - REG_W;
    localparam int DST_RI_LSB = SRCB_LSB;

    localparam logic [OPC_W-1:0] OP_SRUI    = 6'd0;
    localparam logic [OPC_W-1:0] OP_NORI    = 6'd1;
    localparam logic [OPC_W-1:0] OP_MULI    = 6'd2;
    localparam logic [OPC_W-1:0] OP_SRI     = 6'd5;
    localparam logic [OPC_W-1:0] OP_XORI    = 6'd6;
    localparam logic [OPC_W-1:0] OP_ANDI    = 6'd8;
    localparam logic [OPC_W-1:0] OP_XNORI   = 6'd9;
    localparam logic [OPC_W-1:0] OP_ADDI    = 6'd13;
    localparam logic [OPC_W-1:0] OP_ORI     = 6'd14;
    localparam logic [OPC_W-1:0] OP_SLI     = 6'd15;
    localparam logic [OPC_W-1:0] OP_ANDHI   = 6'd24;
    localparam logic [OPC_W-1:0] OP_CMPEQI  = 6'd25;
    localparam logic [OPC_W-1:0] OP_CMPGTI  = 6'd26;
    localparam logic [OPC_W-1:0] OP_CMPGEI  = 6'd27;
    localparam logic [OPC_W-1:0] OP_CMPGEUI = 6'd28;
    localparam logic [OPC_W-1:0] OP_CMPGTUI = 6'd29;
    localparam logic [OPC_W-1:0] OP_ORHI    = 6'd30;
    localparam logic [OPC_W-1:0] OP_CMPNEI  = 6'd31;
    localparam logic [OPC_W-1:0] OP_SRU     = 6'd32;
    localparam logic [OPC_W-1:0] OP_NOR     = 6'd33;
    localparam logic [OPC_W-1:0] OP_MUL     = 6'd34;
    localparam logic [OPC_W-1:0] OP_SRA     = 6'd37;
    localparam logic [OPC_W-1:0] OP_XOR     = 6'd38;
    localparam logic [OPC_W-1:0] OP_AND     = 6'd40;
    localparam logic [OPC_W-1:0] OP_XNOR    = 6'd41;
    localparam logic [OPC_W-1:0] OP_SEXTB   = 6'd44;
    localparam logic [OPC_W-1:0] OP_ADD     = 6'd45;
    localparam logic [OPC_W-1:0] OP_OR      = 6'd46;
    localparam logic [OPC_W-1:0] OP_SL      = 6'd47;
    localparam logic [OPC_W-1:0] OP_SUB     = 6'd50;
    localparam logic [OPC_W-1:0] OP_SEXTH   = 6'd55;
    localparam logic [OPC_W-1:0] OP_CMPEQ   = 6'd57;
    localparam logic [OPC_W-1:0] OP_CMPGT   = 6'd58;
    localparam logic [OPC_W-1:0] OP_CMPGE   = 6'd59;
    localparam logic [OPC_W-1:0] OP_CMPGEU  = 6'd60;
    localparam logic [OPC_W-1:0] OP_CMPGTU  = 6'd61;
    localparam logic [OPC_W-1:0] OP_CMPNE   = 6'd63;

    typedef enum logic [4:0] {
        FN_ADD, FN_SUB, FN_MUL, FN_AND, FN_OR, FN_XOR, FN_NOR, FN_XNOR,
        FN_EQ, FN_NE, FN_GT, FN_GE, FN_GTU, FN_GEU,
        FN_SHL, FN_SHRA, FN_SHRL, FN_SXB, FN_SXH
    } alu_fn_e;

    typedef enum logic [1:0] {
        EXT_SIGN, EXT_ZERO, EXT_HIGH
    } imm_mode_e;

endpackage

// File: rtl/alu_exec_decode.sv
// Module: opcode decoder. Maps the major opcode to an operation, an operand
// form and an immediate rule, flags opcodes outside the supported set and
// picks the destination field that belongs to the form.
// Assumes: unsupported opcodes are treated as register-register for the
// destination field.
module alu_exec_decode
    import alu_exec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [REG_W-1:0] dst_rr,
    input  logic [REG_W-1:0] dst_ri,
    output alu_fn_e          fn,
    output imm_mode_e        imm_mode,
    output logic             use_imm,
    output logic             known,
    output logic [REG_W-1:0] dest
);

    // Operation, form and immediate rule for each opcode.
    always_comb begin
        fn       = FN_ADD;
        imm_mode = EXT_SIGN;
        use_imm  = 1'b0;
        known    = 1'b1;
        case (opcode)
            OP_ADD:     fn = FN_ADD;
            OP_SUB:     fn = FN_SUB;
            OP_MUL:     fn = FN_MUL;
            OP_AND:     fn = FN_AND;
            OP_OR:      fn = FN_OR;
            OP_XOR:     fn = FN_XOR;
            OP_NOR:     fn = FN_NOR;
            OP_XNOR:    fn = FN_XNOR;
            OP_CMPEQ:   fn = FN_EQ;
            OP_CMPNE:   fn = FN_NE;
            OP_CMPGT:   fn = FN_GT;
            OP_CMPGE:   fn = FN_GE;
            OP_CMPGTU:  fn = FN_GTU;
            OP_CMPGEU:  fn = FN_GEU;
            OP_SL:      fn = FN_SHL;
            OP_SRA:     fn = FN_SHRA;
            OP_SRU:     fn = FN_SHRL;
            OP_SEXTB:   fn = FN_SXB;
            OP_SEXTH:   fn = FN_SXH;
            OP_ADDI: begin
                fn = FN_ADD;  use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_MULI: begin
                fn = FN_MUL;  use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_CMPEQI: begin
                fn = FN_EQ;   use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_CMPNEI: begin
                fn = FN_NE;   use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_CMPGTI: begin
                fn = FN_GT;   use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_CMPGEI: begin
                fn = FN_GE;   use_imm = 1'b1; imm_mode = EXT_SIGN;
            end
            OP_CMPGTUI: begin
                fn = FN_GTU;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_CMPGEUI: begin
                fn = FN_GEU;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_ANDI: begin
                fn = FN_AND;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_ORI: begin
                fn = FN_OR;   use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_XORI: begin
                fn = FN_XOR;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_NORI: begin
                fn = FN_NOR;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_XNORI: begin
                fn = FN_XNOR; use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_ANDHI: begin
                fn = FN_AND;  use_imm = 1'b1; imm_mode = EXT_HIGH;
            end
            OP_ORHI: begin
                fn = FN_OR;   use_imm = 1'b1; imm_mode = EXT_HIGH;
            end
            OP_SLI: begin
                fn = FN_SHL;  use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_SRI: begin
                fn = FN_SHRA; use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            OP_SRUI: begin
                fn = FN_SHRL; use_imm = 1'b1; imm_mode = EXT_ZERO;
            end
            default:    known = 1'b0;
        endcase
    end

    // Destination field moves with the operand form.
    always_comb dest = use_imm ? dst_ri : dst_rr;

endmodule

// File: rtl/alu_exec_immext.sv
// Module: immediate extender. Widens the 16-bit immediate to the datapath
// width by sign extension, zero extension or placement in the upper half.
// Assumes: DATA_W is at least twice IMM_W.
module alu_exec_immext
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  imm_mode_e         mode,
    output logic [DATA_W-1:0] value
);

    localparam int PAD_W = DATA_W - IMM_W;

    // Select the widening rule for this operation.
    always_comb begin
        case (mode)
            EXT_SIGN: value = {{PAD_W{imm[IMM_W-1]}}, imm};
            EXT_HIGH: value = {{PAD_W{1'b0}}, imm} << IMM_W;
            default:  value = {{PAD_W{1'b0}}, imm};
        endcase
    end

endmodule

// File: rtl/alu_exec_core.sv
// Module: combinational operation unit. Evaluates arithmetic, bitwise,
// compare, shift and sign-extension operations on two operands.
// Assumes: the shift amount is the low log2(DATA_W) bits of operand B.
module alu_exec_core
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_fn_e           fn,
    output logic [DATA_W-1:0] result
);

    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;

    logic [SHAMT_W-1:0] shamt;
    logic [DATA_W-1:0]  product;
    logic [DATA_W-1:0]  diff;
    logic               rel;

    // Shift amount and low product word.
    always_comb begin
        shamt   = opb[SHAMT_W-1:0];
        product = opa * opb;
        diff    = opa - opb;
    end

    // Compare relation for the compare operations.
    always_comb begin
        case (fn)
            FN_EQ:   rel = (opa == opb);
            FN_NE:   rel = (opa != opb);
            FN_GT:   rel = ($signed(opa) > $signed(opb));
            FN_GE:   rel = ($signed(opa) >= $signed(opb));
            FN_GTU:  rel = (opa > opb);
            FN_GEU:  rel = (opa >= opb);
            default: rel = 1'b0;
        endcase
    end

    // Result select.
    always_comb begin
        case (fn)
            FN_ADD:  result = opa + opb;
            FN_SUB:  result = diff;
            FN_MUL:  result = product;
            FN_AND:  result = opa & opb;
            FN_OR:   result = opa | opb;
            FN_XOR:  result = opa ^ opb;
            FN_NOR:  result = ~(opa | opb);
            FN_XNOR: result = ~(opa ^ opb);
            FN_EQ, FN_NE, FN_GT, FN_GE, FN_GTU, FN_GEU:
                     result = {{(DATA_W-1){1'b0}}, rel};
            FN_SHL:  result = opa << shamt;
            FN_SHRA: result = $unsigned($signed(opa) >>> shamt);
            FN_SHRL: result = opa >> shamt;
            FN_SXB:  result = {{(DATA_W-BYTE_W){opa[BYTE_W-1]}}, opa[BYTE_W-1:0]};
            FN_SXH:  result = {{(DATA_W-HALF_W){opa[HALF_W-1]}}, opa[HALF_W-1:0]};
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/alu_exec.sv
// Module: integer execute stage top. Splits the instruction into fields,
// drives the source indices, decodes, extends the immediate, evaluates the
// operation and registers result, destination, write enable and flags.
// Assumes: src_a_val/src_b_val hold the registers named by src_a_idx/src_b_idx
// in the same cycle.
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   src_a_val,
    input  logic [DATA_W-1:0]   src_b_val,
    output logic [REG_W-1:0]    src_a_idx,
    output logic [REG_W-1:0]    src_b_idx,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_result,
    output logic [REG_W-1:0]    out_dest,
    output logic                out_wen,
    output logic                out_unsupported
);

    logic [OPC_W-1:0]  opcode;
    logic [REG_W-1:0]  dst_rr;
    logic [REG_W-1:0]  dst_ri;
    logic [IMM_W-1:0]  imm;
    alu_fn_e           fn;
    imm_mode_e         imm_mode;
    logic              use_imm;
    logic              known;
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] core_res;

    // Instruction field split.
    always_comb begin
        opcode    = instr[OPC_LSB +: OPC_W];
        src_a_idx = instr[SRCA_LSB +: REG_W];
        src_b_idx = instr[SRCB_LSB +: REG_W];
        dst_rr    = instr[DST_RR_LSB +: REG_W];
        dst_ri    = instr[DST_RI_LSB +: REG_W];
        imm       = instr[IMM_W-1:0];
    end

    alu_exec_decode u_decode (
        .opcode   (opcode),
        .dst_rr   (dst_rr),
        .dst_ri   (dst_ri),
        .fn       (fn),
        .imm_mode (imm_mode),
        .use_imm  (use_imm),
        .known    (known),
        .dest     (dest)
    );

    alu_exec_immext #(.DATA_W(DATA_W)) u_immext (
        .imm   (imm),
        .mode  (imm_mode),
        .value (imm_val)
    );

    // Second operand: immediate or register.
    always_comb opb = use_imm ? imm_val : src_b_val;

    alu_exec_core #(.DATA_W(DATA_W)) u_core (
        .opa    (src_a_val),
        .opb    (opb),
        .fn     (fn),
        .result (core_res)
    );

    // Output register stage; result and destination load only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_wen         <= 1'b0;
            out_unsupported <= 1'b0;
            out_result      <= '0;
            out_dest        <= '0;
        end else begin
            out_valid       <= in_valid;
            out_wen         <= in_valid && known && (dest != '0);
            out_unsupported <= in_valid && !known;
            if (in_valid) begin
                out_result <= known ? core_res : '0;
                out_dest   <= dest;
            end
        end
    end

    assert_wen_dest_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> (out_dest != '0));

    assert_unsup_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_unsupported |-> (!out_wen && out_result == '0 && out_valid));

    assert_issue_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wen && !out_unsupported
                       && $stable(out_result) && $stable(out_dest)));

endmodule

// File: tb/alu_exec_bench.sv
module alu_exec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a_val = '0;
    logic [31:0] src_b_val = '0;
    logic [4:0]  src_a_idx, src_b_idx;
    logic        out_valid, out_wen, out_unsupported;
    logic [31:0] out_result;
    logic [4:0]  out_dest;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        e_valid = 1'b0, e_wen = 1'b0, e_uns = 1'b0;
    logic [31:0] e_res = '0;
    logic [4:0]  e_dest = '0;
    string       e_tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_exec u_alu_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a_val(src_a_val), .src_b_val(src_b_val),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest),
        .out_wen(out_wen), .out_unsupported(out_unsupported)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_for(input logic [5:0] op);
        case (op)
            45, 50, 34, 40, 46, 38, 33, 41: return "R1";
            13, 2:                          return "R2";
            8, 14, 6, 1, 9:                 return "R3";
            24, 30:                         return "R4";
            57, 58, 59, 60, 61, 63,
            25, 26, 27, 28, 29, 31:         return "R5";
            47, 15, 37, 5, 32, 0:           return "R6";
            44, 55:                         return "R7";
            default:                        return "R10";
        endcase
    endfunction

    // Reference model computed from the requirement text.
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [4:0] d,
                         output logic w, output logic u);
        logic [5:0]  op;
        logic [31:0] si, zi, hi;
        logic [4:0]  dr, di;
        op = ins[31:26];
        si = {{16{ins[15]}}, ins[15:0]};
        zi = {16'h0, ins[15:0]};
        hi = {ins[15:0], 16'h0};
        dr = ins[15:11];
        di = ins[20:16];
        u  = 1'b0;
        d  = dr;
        r  = '0;
        case (op)
            45: r = a + b;
            50: r = a - b;
            34: r = a * b;
            40: r = a & b;
            46: r = a | b;
            38: r = a ^ b;
            33: r = ~(a | b);
            41: r = ~(a ^ b);
            57: r = {31'h0, a == b};
            58: r = {31'h0, $signed(a) > $signed(b)};
            59: r = {31'h0, $signed(a) >= $signed(b)};
            60: r = {31'h0, a >= b};
            61: r = {31'h0, a > b};
            63: r = {31'h0, a != b};
            47: r = a << b[4:0];
            37: r = $unsigned($signed(a) >>> b[4:0]);
            32: r = a >> b[4:0];
            44: r = {{24{a[7]}}, a[7:0]};
            55: r = {{16{a[15]}}, a[15:0]};
            13: begin r = a + si; d = di; end
            2:  begin r = a * si; d = di; end
            25: begin r = {31'h0, a == si}; d = di; end
            26: begin r = {31'h0, $signed(a) > $signed(si)}; d = di; end
            27: begin r = {31'h0, $signed(a) >= $signed(si)}; d = di; end
            31: begin r = {31'h0, a != si}; d = di; end
            28: begin r = {31'h0, a >= zi}; d = di; end
            29: begin r = {31'h0, a > zi}; d = di; end
            8:  begin r = a & zi; d = di; end
            14: begin r = a | zi; d = di; end
            6:  begin r = a ^ zi; d = di; end
            1:  begin r = ~(a | zi); d = di; end
            9:  begin r = ~(a ^ zi); d = di; end
            24: begin r = a & hi; d = di; end
            30: begin r = a | hi; d = di; end
            15: begin r = a << ins[4:0]; d = di; end
            5:  begin r = $unsigned($signed(a) >>> ins[4:0]); d = di; end
            0:  begin r = a >> ins[4:0]; d = di; end
            default: begin u = 1'b1; r = '0; end
        endcase
        w = !u && (d != 5'd0);
    endtask

    // Compare registered outputs against the expectation of the previous issue.
    task automatic check_outputs();
        chk({"R8 valid (", e_tag, ")"}, {31'h0, out_valid}, {31'h0, e_valid});
        chk({e_tag, " result"}, out_result, e_res);
        chk({e_tag, " dest"}, {27'h0, out_dest}, {27'h0, e_dest});
        chk({"R9 wen (", e_tag, ")"}, {31'h0, out_wen}, {31'h0, e_wen});
        chk({"R10 unsupported (", e_tag, ")"}, {31'h0, out_unsupported}, {31'h0, e_uns});
    endtask

    // One cycle: check previous result, then drive new stimulus at the falling edge.
    task automatic step(input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic [4:0]  d;
        logic        w, u;
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        instr     = ins;
        src_a_val = a;
        src_b_val = b;
        #1;
        chk("R1 src_a_idx", {27'h0, src_a_idx}, {27'h0, ins[25:21]});
        chk("R1 src_b_idx", {27'h0, src_b_idx}, {27'h0, ins[20:16]});
        if (v) begin
            model(ins, a, b, r, d, w, u);
            e_valid = 1'b1; e_res = r; e_dest = d; e_wen = w; e_uns = u;
            e_tag = req_for(ins[31:26]);
        end else begin
            e_valid = 1'b0; e_wen = 1'b0; e_uns = 1'b0;
            e_tag = "R8 idle";
        end
    endtask

    function automatic logic [31:0] rr(input int op, input int sa, input int sb, input int dd);
        return {op[5:0], sa[4:0], sb[4:0], dd[4:0], 11'h0};
    endfunction

    function automatic logic [31:0] ri(input int op, input int sa, input int dd, input logic [15:0] im);
        return {op[5:0], sa[4:0], dd[4:0], im};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] a, b, ins;
        void'($urandom(32'h5EED_1234));
        rst_n    = 1'b0;
        in_valid = 1'b1;
        instr    = rr(45, 1, 2, 3);
        src_a_val = 32'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs are zero after reset even with valid input applied.
        chk("R11 valid", {31'h0, out_valid}, 32'h0);
        chk("R11 result", out_result, 32'h0);
        chk("R11 dest", {27'h0, out_dest}, 32'h0);
        chk("R11 wen", {31'h0, out_wen}, 32'h0);
        chk("R11 unsupported", {31'h0, out_unsupported}, 32'h0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        e_tag    = "R11";

        // Directed corner cases.
        step(1, ri(13, 0, 0, 16'h0), 32'h0, 32'h0);                  // R9 no-op
        step(1, ri(13, 4, 7, 16'h8000), 32'h0000_0010, 32'hFFFF);    // R2 sign ext
        step(1, ri(14, 4, 9, 16'hFFFF), 32'hA000_0000, 32'h0);       // R3 zero ext
        step(1, ri(24, 2, 5, 16'hF0F0), 32'h1234_5678, 32'h0);       // R4 andhi
        step(1, ri(30, 2, 6, 16'hABCD), 32'h0000_1111, 32'h0);       // R4 orhi
        step(1, ri(27, 1, 8, 16'hFFFE), 32'hFFFF_FFFE, 32'h0);       // R5 ge signed imm
        step(1, ri(28, 1, 8, 16'hFFFE), 32'hFFFF_FFFE, 32'h0);       // R5 geu zero-ext imm
        step(1, rr(61, 1, 2, 10), 32'h8000_0000, 32'h7FFF_FFFF);      // R5 gtu
        step(1, rr(58, 1, 2, 10), 32'h8000_0000, 32'h7FFF_FFFF);      // R5 gt
        step(1, rr(47, 1, 2, 11), 32'h0000_0003, 32'h0000_0021);      // R6 amount low 5 bits
        step(1, rr(37, 1, 2, 11), 32'h8000_0000, 32'hFFFF_FFE4);      // R6 arith
        step(1, ri(0, 1, 12, 16'h003F), 32'h8000_0000, 32'h0);        // R6 srui imm low bits
        step(1, rr(44, 1, 0, 13), 32'h1234_5680, 32'h0);              // R7 byte
        step(1, rr(55, 1, 0, 13), 32'h0000_7FFF, 32'h0);              // R7 half
        step(1, rr(35, 1, 2, 14), 32'h10, 32'h2);                     // R10 divide
        step(1, rr(52, 1, 2, 0), 32'h10, 32'h2);                      // R10 with dest 0
        step(0, rr(45, 1, 2, 15), 32'h10, 32'h2);                     // R8 idle hold
        step(0, 32'hFFFF_FFFF, 32'h5, 32'h6);                         // R8 idle hold
        step(1, rr(57, 3, 4, 0), 32'h5, 32'h5);                       // R9 compare to r0
        step(1, rr(34, 3, 4, 20), 32'hFFFF_FFFF, 32'hFFFF_FFFF);      // R1 mul low word

        // Constrained random mix.
        for (int i = 0; i < N_RANDOM; i++) begin
            int sel;
            sel = $urandom % 8;
            ins = $urandom;
            a   = $urandom;
            case (sel)
                0: a = 32'h8000_0000;
                1: a = 32'h7FFF_FFFF;
                2: a = {16'h0, ins[15:0]};
                default: ;
            endcase
            b = (sel == 3) ? a : $urandom;
            step(($urandom % 8) != 0, ins, a, b);
        end
        step(0, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        check_outputs();
        finish_run();
    end

endmodule